// File: doc/BRIEF.md
# Event-Channel Quadrature Decoder

This block sits at the output of a bank of event channels and turns two of them into a quadrature decoder. A decoder instance on channel `c` reads channel `c` as phase A, channel `c+1` as phase B and channel `c+2` as the index input. It emits single-cycle increment, decrement, index and illegal-transition strobes for a downstream position counter. Every channel also passes its own event through, delayed by one register, whatever the decoder configuration is.

Only the channels named in a build-time mask carry a decoder. The default mask places decoders on channels 0, 2 and 4. On any other channel the decoder enable, index enable and recognition mode are accepted at the port but have no effect, and that channel acts as a plain event channel. Each decoder has its own enable, its own index enable and a two-bit recognition mode. The mode names the phase levels that must be present for an index pulse to be accepted.

Top module: `quad_event_decoder`

## Requirements
- R1: On every channel, `ev_out[c]` equals the value of `ev_in[c]` at the previous rising clock edge, whatever the decoder configuration.
- R2: On a decoder channel `c`, A is `ev_in[c]`, B is `ev_in[c+1]` and the phase state is written {A,B}. A move to the next state in the order 00, 10, 11, 01, 00 raises `inc_stb[c]` for exactly one cycle, one cycle after the input change.
- R3: A move to the next state in the order 00, 01, 11, 10, 00 raises `dec_stb[c]` for exactly one cycle, one cycle after the input change.
- R4: When the phase state does not change, an enabled decoder raises none of the increment, decrement or error strobes.
- R5: A change of both phase bits in one cycle raises `err_stb[c]` for one cycle and raises neither `inc_stb[c]` nor `dec_stb[c]`.
- R6: In the first enabled cycle after reset, and in the first cycle after the enable rises, the decoder only records the current phase state and raises no increment, decrement or error strobe.
- R7: While `cfg_qd_en[c]` is low, all four strobes of channel `c` stay low, including when index pulses arrive.
- R8: With both enables high, `idx_stb[c]` pulses for one cycle, one cycle after the index input `ev_in[c+2]` becomes qualified. The index is qualified when the index input is high, A equals bit 1 of `cfg_idx_mode[2c+1:2c]` and B equals bit 0 of that field. The strobe stays low while the qualification is held.
- R9: While `cfg_idx_en[c]` is low, `idx_stb[c]` stays low but counting continues.
- R10: On channels without a decoder (1, 3, 5, 6 and 7 by default), all four strobes stay low under any configuration and input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_CH | Event level of each channel |
| cfg_qd_en | input | NUM_CH | Decoder enable per channel |
| cfg_idx_en | input | NUM_CH | Index enable per channel |
| cfg_idx_mode | input | 2*NUM_CH | Index recognition mode per channel, two bits each: bit 1 is the A level, bit 0 the B level |
| ev_out | output | NUM_CH | Registered event pass-through |
| inc_stb | output | NUM_CH | Count-up strobe |
| dec_stb | output | NUM_CH | Count-down strobe |
| idx_stb | output | NUM_CH | Index strobe |
| err_stb | output | NUM_CH | Illegal transition strobe |

## Verification
Every result of this block comes one register after its cause. A phase or index change driven on the falling edge is taken at the next rising edge, and the strobe it causes can be read at the falling edge after that. The pass-through follows the same timing. The bench therefore drives on one falling edge and compares at the next. Before each transition it holds the phase state for two cycles, so that the strobes from the setup move have cleared before the move under test. For the one-cycle-wide index strobe it also checks that the strobe is low again one cycle later.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    // Value equals the modular distance along the count-up Gray walk.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_BAD  = 2'd2,
        STEP_DOWN = 2'd3
    } step_e;

    typedef struct packed {
        logic inc;
        logic dec;
        logic idx;
        logic err;
    } strobe_t;

    // Position of a phase state on the walk 00 -> 10 -> 11 -> 01.
    function automatic logic [1:0] gray_pos(phase_t p);
        return {p.b, p.a ^ p.b};
    endfunction

    function automatic step_e classify(phase_t prv, phase_t cur);
        logic [1:0] d;
        d = gray_pos(cur) - gray_pos(prv);
        return step_e'(d);
    endfunction

endpackage

// File: rtl/ev_stage.sv
module ev_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/qdec_index_match.sv
module qdec_index_match
    import qdec_pkg::*;
(
    input  logic       enable,
    input  phase_t     phase,
    input  logic       idx,
    input  logic [1:0] mode,
    output logic       qual
);
    always_comb begin
        qual = enable && idx && (phase.a == mode[1]) && (phase.b == mode[0]);
    end
endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       idx_en,
    input  logic [1:0] idx_mode,
    input  logic       ph_a,
    input  logic       ph_b,
    input  logic       idx,
    output strobe_t    stb
);
    phase_t  cur;
    phase_t  prv_q;
    logic    armed_q;
    logic    qual;
    logic    qual_q;
    step_e   step;
    strobe_t stb_d;
    strobe_t stb_q;

    assign cur = {ph_a, ph_b};

    qdec_index_match u_match (
        .enable (en & idx_en),
        .phase  (cur),
        .idx    (idx),
        .mode   (idx_mode),
        .qual   (qual)
    );

    always_comb begin
        step  = classify(prv_q, cur);
        stb_d = '0;
        if (en && armed_q) begin
            stb_d.inc = (step == STEP_UP);
            stb_d.dec = (step == STEP_DOWN);
            stb_d.err = (step == STEP_BAD);
        end
        stb_d.idx = qual & ~qual_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q   <= '0;
            armed_q <= 1'b0;
            qual_q  <= 1'b0;
            stb_q   <= '0;
        end else begin
            prv_q   <= cur;
            armed_q <= en;
            qual_q  <= qual;
            stb_q   <= stb_d;
        end
    end

    assign stb = stb_q;

    // R2: a count-up strobe follows a single-bit phase change
    a_r2_up_single_bit: assert property (@(posedge clk) disable iff (rst)
        stb_q.inc |-> ($countones(prv_q ^ $past(prv_q)) == 1));

    // R3: a count-down strobe follows a single-bit phase change
    a_r3_dn_single_bit: assert property (@(posedge clk) disable iff (rst)
        stb_q.dec |-> ($countones(prv_q ^ $past(prv_q)) == 1));

    // R5: an error excludes counting and follows a two-bit change
    a_r5_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        stb_q.err |-> (!stb_q.inc && !stb_q.dec && (prv_q != $past(prv_q))));

    // R6: the first enabled cycle only records the state
    a_r6_first_quiet: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> !(stb_q.inc || stb_q.dec || stb_q.err));

    // R7: a disabled decoder stays silent
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> (stb_q == '0));

    // R8: the index strobe is one cycle wide
    a_r8_idx_one_cycle: assert property (@(posedge clk) disable iff (rst)
        stb_q.idx |=> !stb_q.idx);

endmodule

// File: rtl/quad_event_decoder.sv
module quad_event_decoder
    import qdec_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter logic [63:0] QD_CH_MASK = 64'h15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     ev_in,
    input  logic [NUM_CH-1:0]     cfg_qd_en,
    input  logic [NUM_CH-1:0]     cfg_idx_en,
    input  logic [2*NUM_CH-1:0]   cfg_idx_mode,
    output logic [NUM_CH-1:0]     ev_out,
    output logic [NUM_CH-1:0]     inc_stb,
    output logic [NUM_CH-1:0]     dec_stb,
    output logic [NUM_CH-1:0]     idx_stb,
    output logic [NUM_CH-1:0]     err_stb
);
    localparam int SPAN = 3;

    ev_stage #(.WIDTH(NUM_CH)) u_pass (
        .clk (clk),
        .rst (rst),
        .d   (ev_in),
        .q   (ev_out)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (QD_CH_MASK[c] && (c + SPAN <= NUM_CH)) begin : g_qd
            strobe_t s;
            qdec_core u_core (
                .clk      (clk),
                .rst      (rst),
                .en       (cfg_qd_en[c]),
                .idx_en   (cfg_idx_en[c]),
                .idx_mode (cfg_idx_mode[2*c +: 2]),
                .ph_a     (ev_in[c]),
                .ph_b     (ev_in[c+1]),
                .idx      (ev_in[c+2]),
                .stb      (s)
            );
            assign inc_stb[c] = s.inc;
            assign dec_stb[c] = s.dec;
            assign idx_stb[c] = s.idx;
            assign err_stb[c] = s.err;
        end else begin : g_plain
            // Decoder requests on this channel are accepted and discarded.
            logic discard;
            assign discard = (cfg_qd_en[c] | cfg_idx_en[c] | (|cfg_idx_mode[2*c +: 2])) & 1'b0;
            assign inc_stb[c] = discard;
            assign dec_stb[c] = discard;
            assign idx_stb[c] = discard;
            assign err_stb[c] = discard;
        end
    end

endmodule

// File: tb/sim_quad_event_decoder.sv
`timescale 1ns/1ps
module sim_quad_event_decoder;
    localparam int N = 8;
    localparam logic [7:0] QMASK = 8'h15;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] ev_in, cfg_qd_en, cfg_idx_en;
    logic [2*N-1:0] cfg_idx_mode;
    logic [N-1:0] ev_out, inc_stb, dec_stb, idx_stb, err_stb;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    quad_event_decoder #(.NUM_CH(N), .QD_CH_MASK(64'h15)) u0 (
        .clk(clk), .rst(rst), .ev_in(ev_in), .cfg_qd_en(cfg_qd_en),
        .cfg_idx_en(cfg_idx_en), .cfg_idx_mode(cfg_idx_mode), .ev_out(ev_out),
        .inc_stb(inc_stb), .dec_stb(dec_stb), .idx_stb(idx_stb), .err_stb(err_stb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input int c, input logic [1:0] ab, input logic ix);
        ev_in = '0;
        ev_in[c]   = ab[1];
        ev_in[c+1] = ab[0];
        ev_in[c+2] = ix;
    endtask

    function automatic logic [1:0] pos(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

    function automatic logic [7:0] onehot(input logic v, input int c);
        return v ? (8'h1 << c) : 8'h0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; ev_in = '0; cfg_qd_en = '0; cfg_idx_en = '0; cfg_idx_mode = '0;
        repeat (3) @(negedge clk);
        chk("R6 reset strobes", {inc_stb, dec_stb, idx_stb, err_stb}, 32'h0);
        chk("R1 reset pass", ev_out, 0);
        rst = 1'b0;

        // R1: pass-through
        begin
            logic [7:0] last;
            for (int k = 0; k < 16; k++) begin
                last = 8'(k * 37 + 5);
                ev_in = last;
                cfg_qd_en = 8'(k * 11);
                @(negedge clk);
                chk("R1 pass", ev_out, last);
            end
        end
        cfg_qd_en = '0;

        // R2 R3 R4 R5: full transition sweep on each decoder channel
        for (int ci = 0; ci < 3; ci++) begin
            int c = ci * 2;
            cfg_qd_en = 8'h1 << c;
            for (int f = 0; f < 4; f++) begin
                for (int t = 0; t < 4; t++) begin
                    logic [1:0] d;
                    drive(c, 2'(f), 1'b0);
                    repeat (2) @(negedge clk);
                    drive(c, 2'(t), 1'b0);
                    @(negedge clk);
                    d = pos(2'(t)) - pos(2'(f));
                    chk("R2 inc", inc_stb, onehot(d == 2'd1, c));
                    chk("R3 dec", dec_stb, onehot(d == 2'd3, c));
                    chk("R5 err", err_stb, onehot(d == 2'd2, c));
                    if (d == 2'd0) chk("R4 hold", {inc_stb, dec_stb, err_stb}, 0);
                end
            end
        end

        // R8: index recognition sweep
        for (int ci = 0; ci < 3; ci++) begin
            int c = ci * 2;
            cfg_qd_en = 8'h1 << c;
            cfg_idx_en = 8'h1 << c;
            for (int m = 0; m < 4; m++) begin
                cfg_idx_mode = '0;
                cfg_idx_mode[2*c +: 2] = 2'(m);
                for (int s = 0; s < 4; s++) begin
                    drive(c, 2'(s), 1'b0);
                    repeat (2) @(negedge clk);
                    drive(c, 2'(s), 1'b1);
                    @(negedge clk);
                    chk("R8 idx", idx_stb, onehot(s == m, c));
                    @(negedge clk);
                    chk("R8 idx single", idx_stb, 0);
                    drive(c, 2'(s), 1'b0);
                end
            end
        end

        // R9: index disabled, counting continues
        cfg_qd_en = 8'h01; cfg_idx_en = '0; cfg_idx_mode = '0;
        drive(0, 2'b00, 1'b0);
        repeat (2) @(negedge clk);
        drive(0, 2'b00, 1'b1);
        @(negedge clk);
        chk("R9 idx off", idx_stb, 0);
        drive(0, 2'b10, 1'b1);
        @(negedge clk);
        chk("R9 count on", inc_stb, 8'h01);
        chk("R9 idx off still", idx_stb, 0);

        // R7: disabled decoders stay silent
        cfg_qd_en = '0; cfg_idx_en = 8'hFF; cfg_idx_mode = '0;
        for (int k = 0; k < 24; k++) begin
            ev_in = 8'(k * 29 + 3);
            @(negedge clk);
            chk("R7 off", {inc_stb, dec_stb, idx_stb, err_stb}, 0);
        end

        // R6: enable edge and reset exit record state only
        cfg_idx_en = '0;
        drive(0, 2'b11, 1'b0);
        repeat (2) @(negedge clk);
        cfg_qd_en = 8'h01;
        drive(0, 2'b10, 1'b0);
        @(negedge clk);
        chk("R6 enable quiet", {inc_stb, dec_stb, err_stb}, 0);
        drive(0, 2'b00, 1'b0);
        @(negedge clk);
        chk("R6 then counts (R3)", dec_stb, 8'h01);
        drive(0, 2'b11, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(0, 2'b10, 1'b0);
        @(negedge clk);
        chk("R6 reset exit quiet", {inc_stb, dec_stb, err_stb}, 0);
        drive(0, 2'b11, 1'b0);
        @(negedge clk);
        chk("R6 then counts (R2)", inc_stb, 8'h01);

        // R10: channels without a decoder stay silent
        cfg_qd_en = 8'hFF; cfg_idx_en = 8'hFF; cfg_idx_mode = '0;
        for (int k = 0; k < 40; k++) begin
            ev_in = 8'((k * 53) ^ k);
            @(negedge clk);
            chk("R10 absent", (inc_stb | dec_stb | idx_stb | err_stb) & ~QMASK, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule